// File: doc/BRIEF.md
# Hamming Syndrome Checker and Byte Corrector

This block checks one 256-byte chunk of flash data against its error code. It takes the 24-bit code that was stored with the chunk and the 24-bit code that was computed again over the data read back. Only the low 22 bits of each code carry parity: an 11-bit half of line parities and an 11-bit half of their complements. The block XORs the two codes into a syndrome and sorts the result into one of four classes: clean, damaged code, correctable single-bit data error, or uncorrectable. For a correctable error it reports the byte offset and the bit index inside that byte. A combinational patch port then flips that bit in any byte presented to it whose offset matches.

A pulse on `start` loads both codes. The class and the location are registered on that clock edge, and `done` is high for exactly the following cycle. The inputs have no back-pressure. A start is accepted on every cycle, including back-to-back cycles, and each start gives one `done` one cycle later. The registered outputs hold until the next start. A 512-byte page is checked as two separate operations whose code pairs sit 8 bytes apart in the spare area. The caller ORs the two failure indications.

Top module: `hamm_syn_fix`

## Requirements
- R1: The syndrome uses bits 21:0 of each code only. Bits 23:22 of either code have no effect on any output.
- R2: If the syndrome is zero, or bits 21:0 of either code are all zero, `result` becomes 2'b00 (clean). `fix_byte` and `fix_bit` become zero.
- R3: If the syndrome has exactly one bit set and neither rule of R2 applies, `result` becomes 2'b01 (code damaged). The patch port passes data unchanged.
- R4: `result` becomes 2'b10 (correctable) only when the syndrome has exactly 11 bits set, neither rule of R2 applies, and each code's low half (bits 10:0) XOR its high half (bits 21:11) differs between the two codes in all 11 positions.
- R5: On a correctable result, `fix_bit` is syndrome bits 2:0 and `fix_byte` is syndrome bits 10:3. On any other result, both are zero.
- R6: Every syndrome not covered by R2, R3 or R4 gives `result` 2'b11 (uncorrectable).
- R7: `result`, `fix_byte` and `fix_bit` update on the clock edge that samples `start`. `done` is high for exactly the next cycle, once for each start, back-to-back starts included.
- R8: While `start` is low, `result`, `fix_byte` and `fix_bit` hold their values and `done` stays low, whatever the code inputs do.
- R9: `patch_out` equals `patch_in` with bit `fix_bit` inverted only when `result` is 2'b10 and `patch_ofs` equals `fix_byte`. Otherwise `patch_out` equals `patch_in`.
- R10: During and after reset (`rst_n` low), `done` is 0, `result` is 2'b00, and `fix_byte` and `fix_bit` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples both codes on this edge |
| calc_code | input | 24 | Code computed over the data read back |
| stored_code | input | 24 | Code read from the spare area |
| done | output | 1 | One-cycle pulse after each start |
| result | output | 2 | 00 clean, 01 code damaged, 10 corrected, 11 uncorrectable |
| fix_byte | output | 8 | Offset of the failing byte in the chunk |
| fix_bit | output | 3 | Index of the failing bit in that byte |
| patch_ofs | input | 8 | Offset of the byte presented for patching |
| patch_in | input | 8 | Byte presented for patching |
| patch_out | output | 8 | Patched or unchanged byte |

## Verification
The hardest state to reach is the correctable class. Random code pairs almost never produce exactly eleven syndrome bits with exactly one set in every parity/complement pair. The stimulus therefore builds the syndrome from a chosen 11-bit location and its complement, XORs it onto a random stored code, and so lands the correctable class with a known byte and bit. It also builds the near miss with eleven bits set but one pair holding both bits set and another pair holding neither, which must be reported as uncorrectable. The patch offset is steered onto the failing byte on about half the cycles, so that the flip path and the pass-through path are both observed.

// File: rtl/hamm_syn_pkg.sv
package hamm_syn_pkg;

  localparam int BIT_IDX_W = 3;
  localparam int BYTE_W    = 1 << BIT_IDX_W;

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'b00,
    ECC_CODE_ERR = 2'b01,
    ECC_FIXED    = 2'b10,
    ECC_FATAL    = 2'b11
  } ecc_res_e;

endpackage

// File: rtl/hamm_popcnt.sv
module hamm_popcnt #(
  parameter  int W    = 22,
  localparam int LEAF = 1 << $clog2(W),
  localparam int CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  // heap-ordered adder tree: node 1 is the root, leaves at LEAF..2*LEAF-1
  logic [CW-1:0] node [1:2*LEAF-1];

  for (genvar i = 0; i < LEAF; i++) begin : g_leaf
    if (i < W) begin : g_on
      assign node[LEAF+i] = CW'(vec[i]);
    end else begin : g_pad
      assign node[LEAF+i] = '0;
    end
  end

  for (genvar n = 1; n < LEAF; n++) begin : g_sum
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign cnt = node[1];

endmodule

// File: rtl/hamm_classify.sv
module hamm_classify
  import hamm_syn_pkg::*;
#(
  parameter  int HALF_W = 11,
  localparam int SYN_W  = 2 * HALF_W,
  localparam int CNT_W  = $clog2(SYN_W + 1)
) (
  input  logic [SYN_W-1:0]  calc,
  input  logic [SYN_W-1:0]  stor,
  input  logic [CNT_W-1:0]  ones,
  output logic [SYN_W-1:0]  syn,
  output ecc_res_e          cls,
  output logic [HALF_W-1:0] loc
);

  logic [HALF_W-1:0] calc_fold;
  logic [HALF_W-1:0] stor_fold;
  logic              pairs_split;
  logic              trivially_clean;

  assign syn       = calc ^ stor;
  assign calc_fold = calc[HALF_W-1:0] ^ calc[SYN_W-1:HALF_W];
  assign stor_fold = stor[HALF_W-1:0] ^ stor[SYN_W-1:HALF_W];
  // every line parity and its complement disagree in exactly one member
  assign pairs_split     = &(calc_fold ^ stor_fold);
  assign trivially_clean = (syn == '0) || (calc == '0) || (stor == '0);

  always_comb begin
    if (trivially_clean) begin
      cls = ECC_CLEAN;
    end else if (ones == CNT_W'(1)) begin
      cls = ECC_CODE_ERR;
    end else if ((ones == CNT_W'(HALF_W)) && pairs_split) begin
      cls = ECC_FIXED;
    end else begin
      cls = ECC_FATAL;
    end
  end

  assign loc = (cls == ECC_FIXED) ? syn[HALF_W-1:0] : '0;

endmodule

// File: rtl/hamm_byte_patch.sv
module hamm_byte_patch
  import hamm_syn_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic                 armed,
  input  logic [OFS_W-1:0]     tgt_ofs,
  input  logic [BIT_IDX_W-1:0] tgt_bit,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [BYTE_W-1:0]    din,
  output logic [BYTE_W-1:0]    dout
);

  logic hit;
  assign hit = armed && (ofs == tgt_ofs);

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign dout[b] = din[b] ^ (hit && (tgt_bit == BIT_IDX_W'(b)));
  end

endmodule

// File: rtl/hamm_syn_fix.sv
module hamm_syn_fix
  import hamm_syn_pkg::*;
#(
  parameter  int CODE_W = 24,
  parameter  int HALF_W = 11,
  localparam int SYN_W  = 2 * HALF_W,
  localparam int CNT_W  = $clog2(SYN_W + 1),
  localparam int OFS_W  = HALF_W - BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CODE_W-1:0]    calc_code,
  input  logic [CODE_W-1:0]    stored_code,
  output logic                 done,
  output logic [1:0]           result,
  output logic [OFS_W-1:0]     fix_byte,
  output logic [BIT_IDX_W-1:0] fix_bit,
  input  logic [OFS_W-1:0]     patch_ofs,
  input  logic [BYTE_W-1:0]    patch_in,
  output logic [BYTE_W-1:0]    patch_out
);

  logic [SYN_W-1:0]  calc_lo;
  logic [SYN_W-1:0]  stor_lo;
  logic [SYN_W-1:0]  syn;
  logic [CNT_W-1:0]  ones;
  ecc_res_e          cls_c;
  logic [HALF_W-1:0] loc_c;
  ecc_res_e          res_q;
  logic [HALF_W-1:0] loc_q;
  logic              unused_hi;

  assign calc_lo   = calc_code[SYN_W-1:0];
  assign stor_lo   = stored_code[SYN_W-1:0];
  assign unused_hi = ^{calc_code[CODE_W-1:SYN_W], stored_code[CODE_W-1:SYN_W]};

  hamm_popcnt #(.W(SYN_W)) u_pop (
    .vec (syn),
    .cnt (ones)
  );

  hamm_classify #(.HALF_W(HALF_W)) u_cls (
    .calc (calc_lo),
    .stor (stor_lo),
    .ones (ones),
    .syn  (syn),
    .cls  (cls_c),
    .loc  (loc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      res_q <= ECC_CLEAN;
      loc_q <= '0;
    end else begin
      done <= start;
      if (start) begin
        res_q <= cls_c;
        loc_q <= loc_c;
      end
    end
  end

  assign result   = res_q;
  assign fix_bit  = loc_q[BIT_IDX_W-1:0];
  assign fix_byte = loc_q[HALF_W-1:BIT_IDX_W];

  hamm_byte_patch #(.OFS_W(OFS_W)) u_patch (
    .armed   (res_q == ECC_FIXED),
    .tgt_ofs (fix_byte),
    .tgt_bit (fix_bit),
    .ofs     (patch_ofs),
    .din     (patch_in),
    .dout    (patch_out)
  );

  assert_done_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(fix_byte) && $stable(fix_bit)));

  assert_equal_codes_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (calc_lo == stor_lo)) |=> (result == 2'b00));

  assert_single_bit_code_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ($countones(calc_lo ^ stor_lo) == 1) && (calc_lo != '0) && (stor_lo != '0))
      |=> (result == 2'b01));

  assert_fixed_has_eleven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (result == 2'b10)) |-> ($countones($past(calc_lo ^ stor_lo)) == HALF_W));

  assert_loc_zero_unless_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (result != 2'b10) |-> ((fix_byte == '0) && (fix_bit == '0)));

  assert_patch_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((result != 2'b10) || (patch_ofs != fix_byte)) |-> (patch_out == patch_in));

endmodule

// File: tb/sim_hamm_syn_fix.sv
module sim_hamm_syn_fix;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] calc_code = '0;
  logic [23:0] stored_code = '0;
  logic        done;
  logic [1:0]  result;
  logic [7:0]  fix_byte;
  logic [2:0]  fix_bit;
  logic [7:0]  patch_ofs = '0;
  logic [7:0]  patch_in = '0;
  logic [7:0]  patch_out;

  int n_chk = 0;
  int n_fail = 0;
  bit running = 1'b0;

  // reference model state
  logic        m_done = 1'b0;
  logic [1:0]  m_res = 2'b00;
  logic [10:0] m_loc = '0;

  always #5 clk = ~clk;

  hamm_syn_fix u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .calc_code(calc_code), .stored_code(stored_code),
    .done(done), .result(result), .fix_byte(fix_byte), .fix_bit(fix_bit),
    .patch_ofs(patch_ofs), .patch_in(patch_in), .patch_out(patch_out)
  );

  function automatic logic [12:0] ref_eval(logic [23:0] c, logic [23:0] s);
    int   ones = 0;
    logic split = 1'b1;
    logic [21:0] sy = c[21:0] ^ s[21:0];
    for (int i = 0; i < 22; i++) ones += sy[i];
    for (int i = 0; i < 11; i++)
      if ((c[i] ^ c[i+11]) == (s[i] ^ s[i+11])) split = 1'b0;
    if (sy == 0 || c[21:0] == 0 || s[21:0] == 0) return {2'b00, 11'd0};
    if (ones == 1) return {2'b01, 11'd0};
    if (ones == 11 && split) return {2'b10, sy[10:0]};
    return {2'b11, 11'd0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done <= 1'b0; m_res <= 2'b00; m_loc <= '0;
    end else begin
      m_done <= start;
      if (start) {m_res, m_loc} <= ref_eval(calc_code, stored_code);
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model (R7 R8 R9)
  always @(negedge clk) begin
    if (running) begin
      logic [7:0] exp_patch;
      exp_patch = patch_in;
      if (m_res == 2'b10 && patch_ofs == m_loc[10:3]) exp_patch[m_loc[2:0]] = ~exp_patch[m_loc[2:0]];
      chk(done == m_done, "R7 done", done, m_done);
      chk({result, fix_byte, fix_bit} == {m_res, m_loc}, "R8 result/location",
          {result, fix_byte, fix_bit}, {m_res, m_loc});
      chk(patch_out == exp_patch, "R9 patch", patch_out, exp_patch);
    end
  end

  task automatic op(logic [23:0] c, logic [23:0] s);
    @(posedge clk); #2;
    start = 1'b1; calc_code = c; stored_code = s;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [21:0] fix_syn(logic [10:0] loc);
    return {~loc, loc};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == 2'b00 && fix_byte == 0 && fix_bit == 0, "R10 reset",
        {done, result, fix_byte, fix_bit}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && result == 2'b00, "R10 after reset", {done, result}, 0);
    running = 1'b1;

    op(24'h012345, 24'h012345);
    chk(result == 2'b00 && fix_byte == 0, "R2 equal", result, 2'b00);
    op(24'h000005, 24'h000000);
    chk(result == 2'b00, "R2 stored zero", result, 2'b00);
    op(24'h000000, 24'h000040);
    chk(result == 2'b00, "R2 calc zero", result, 2'b00);
    op(24'hC12345, 24'h012345);
    chk(result == 2'b00, "R1 upper bits ignored", result, 2'b00);

    op(24'h012345 ^ 24'h020000, 24'h012345);
    chk(result == 2'b01, "R3 single bit", result, 2'b01);
    patch_ofs = 8'h00; patch_in = 8'hA5; #1;
    chk(patch_out == 8'hA5, "R3 R9 no change", patch_out, 8'hA5);

    op({2'b00, 22'h012345 ^ fix_syn(11'h2D3)}, 24'h012345);
    chk(result == 2'b10, "R4 correctable", result, 2'b10);
    chk({fix_byte, fix_bit} == {8'h5A, 3'd3}, "R5 location", {fix_byte, fix_bit}, {8'h5A, 3'd3});
    patch_ofs = 8'h5A; patch_in = 8'h00; #1;
    chk(patch_out == 8'h08, "R9 flip", patch_out, 8'h08);
    patch_in = 8'hFF; #1;
    chk(patch_out == 8'hF7, "R9 flip high", patch_out, 8'hF7);
    patch_ofs = 8'h5B; #1;
    chk(patch_out == 8'hFF, "R9 other offset", patch_out, 8'hFF);

    op({2'b00, 22'h2AAAAA ^ 22'h0007FF}, 24'h2AAAAA);
    chk(result == 2'b10 && fix_byte == 8'hFF && fix_bit == 3'd7, "R5 top corner",
        {result, fix_byte, fix_bit}, {2'b10, 8'hFF, 3'd7});

    op(24'h012345 ^ 24'h000003, 24'h012345);
    chk(result == 2'b11, "R6 two bits", result, 2'b11);
    op(24'h012345 ^ 24'h000BFF, 24'h012345);
    chk(result == 2'b11 && fix_byte == 0, "R6 eleven bits pair fail", result, 2'b11);

    // back-to-back starts
    @(posedge clk); #2;
    start = 1'b1; calc_code = {2'b00, 22'h0F0F0F ^ fix_syn(11'h123)}; stored_code = 24'h0F0F0F;
    @(posedge clk); #2;
    calc_code = 24'h0F0F0F ^ 24'h000030;
    @(negedge clk);
    chk(done && result == 2'b10 && fix_byte == 8'h24, "R7 first of pair", {done, result}, 3'b110);
    @(posedge clk); #2; start = 1'b0;
    @(negedge clk);
    chk(done && result == 2'b11, "R7 second of pair", {done, result}, 3'b111);

    // idle hold
    calc_code = 24'h000001; stored_code = 24'h3FFFFF;
    repeat (3) @(negedge clk);
    chk(!done && result == 2'b11, "R8 hold", {done, result}, 3'b011);

    for (int k = 0; k < 300; k++) begin
      logic [23:0] s, c;
      int kind = $urandom % 5;
      s = $urandom;
      case (kind)
        0: c = s;
        1: c = s ^ (24'd1 << ($urandom % 22));
        2: c = {s[23:22], s[21:0] ^ fix_syn(11'($urandom))};
        3: c = $urandom;
        default: c = {2'($urandom), s[21:0]};
      endcase
      @(posedge clk); #2;
      start = ($urandom % 4) != 0; calc_code = c; stored_code = s;
      patch_in = 8'($urandom);
      patch_ofs = ($urandom % 2) ? m_loc[10:3] : 8'($urandom);
    end
    @(posedge clk); #2; start = 1'b0;
    repeat (3) @(negedge clk);

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule